// File: doc/BRIEF.md
# Banked Set/Clear GPIO Controller

A register-mapped general-purpose I/O controller for up to 128 pins, of which this instance implements 75 (pins 0 to 74). The pins are grouped into banks of 32. Each bank has three write ports that act only on the bits written as one. The first drives the selected pins high, the second drives them low, and the third releases them to input. Writing a level always turns on the pin's drive, so software never issues a separate direction write before it drives a pin.

Pin inputs pass through a two-flop synchroniser. The synchronised levels can be read back per bank. They also feed a per-pin interrupt-request level that is active only while the pin is an input. On the first clock edge after reset is released, the levels of pins 0 to 63 are captured into two read-only words. Software can read these words later to recover the board strapping.

Bank k occupies addresses k*0x20 to k*0x20+0x08. The captured words sit at 0x200 and 0x204. Reads are combinational from `addr_i`. Writes take effect at the clock edge where `we_i` is high.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While `rst_ni` is low, every pin is an input (`gpio_oe_o` = 0), every output latch is 0 (`gpio_o` = 0) and every `irq_o` bit is 0.
- R2: A write to bank offset 0x00 of bank k makes pin 32k+b drive high (`gpio_o` and `gpio_oe_o` bits set) for each 1 in `wdata_i[b]`. Pins whose bit is 0 keep their state. The change is visible after the write's clock edge.
- R3: A write to bank offset 0x04 makes each selected pin drive low (`gpio_o` bit 0, `gpio_oe_o` bit 1). Unselected pins keep their state.
- R4: A write to bank offset 0x08 clears `gpio_oe_o` for each selected pin and leaves its `gpio_o` latch unchanged. Direction changes only on writes.
- R5: A read of bank offset 0x00 returns the bank's pin levels as seen through the two-flop synchroniser. Bit b is pin 32k+b. A level applied to `gpio_i` is readable after two rising edges.
- R6: The word at 0x200 holds pins 0-31 and the word at 0x204 holds pins 32-63, both as synchronised at the first rising edge after reset release. Later pin changes and writes to these addresses do not alter them.
- R7: Bits for pins 75 to 127 read as 0 and ignore writes. Any address outside the map reads as 0.
- R8: `irq_o[p]` is a registered level. It equals pin p's synchronised input while the pin is an input and is 0 while it drives. The edge that changes a pin's direction also updates its request.
- R9: Banks are spaced 0x20 apart: bank 1 starts at 0x20 and bank 2 at 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 10 | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for `addr_i` |
| gpio_i | input | 75 | Pad input levels |
| gpio_o | output | 75 | Output latches |
| gpio_oe_o | output | 75 | Pad drive enables |
| irq_o | output | 75 | Per-pin interrupt request levels |

## Verification
A direction write and the interrupt register's update fall on the same clock edge. A set write to a pin that is an input held high must drop its request at that very edge. A release write on a pin whose pad stays high must raise the request at that edge. The bench holds the external level high and issues each write. At the first falling edge after the write it checks that `irq_o` and `gpio_oe_o` have both moved together, with no cycle of stale request.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BANK_W     = 32;
  localparam int unsigned REG_STRIDE = 32'h20;
  localparam int unsigned OFF_SET    = 32'h00;
  localparam int unsigned OFF_CLR    = 32'h04;
  localparam int unsigned OFF_INP    = 32'h08;
  localparam int unsigned CAP_BASE   = 32'h200;

  function automatic int bank_width(int pins, int k);
    int rem;
    rem = pins - k * BANK_W;
    return (rem > BANK_W) ? BANK_W : rem;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // no reset: the stages must track pads while reset is held
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i) begin
    s1_q <= d_i;
    s2_q <= s1_q;
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic         inp_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] out_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] irq_o
);
  logic [W-1:0] out_q, oe_q, irq_q;
  logic [W-1:0] out_d, oe_d;

  always_comb begin
    out_d = out_q;
    oe_d  = oe_q;
    if (set_we_i) begin
      out_d = out_d | wdata_i;
      oe_d  = oe_d | wdata_i;
    end
    if (clr_we_i) begin
      out_d = out_d & ~wdata_i;
      oe_d  = oe_d | wdata_i;
    end
    if (inp_we_i) oe_d = oe_d & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      oe_q  <= '0;
      irq_q <= '0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
      // next direction, so request and drive switch on one edge
      irq_q <= lvl_i & ~oe_d;
    end
  end

  assign out_o = out_q;
  assign oe_o  = oe_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_rstcap.sv
module gpio_rstcap #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] cap_o,
  output logic         vld_o
);
  logic [W-1:0] cap_q;
  logic         vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      vld_q <= 1'b0;
    end else if (!vld_q) begin
      cap_q <= lvl_i;
      vld_q <= 1'b1;
    end
  end

  assign cap_o = cap_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 75,
  parameter int CAP_PINS = 64,
  parameter int ADDR_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  input  logic                we_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] gpio_i,
  output logic [NUM_PINS-1:0] gpio_o,
  output logic [NUM_PINS-1:0] gpio_oe_o,
  output logic [NUM_PINS-1:0] irq_o
);
  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int PAD_W     = NUM_BANKS * BANK_W;
  localparam int CAP_W     = (CAP_PINS < NUM_PINS) ? CAP_PINS : NUM_PINS;
  localparam int CAP_WORDS = (CAP_W + BANK_W - 1) / BANK_W;
  localparam int CAP_PAD_W = CAP_WORDS * BANK_W;

  logic [NUM_PINS-1:0]  sync_q;
  logic [PAD_W-1:0]     lvl_pad;
  logic [CAP_W-1:0]     cap_q;
  logic                 cap_vld_q;
  logic [CAP_PAD_W-1:0] cap_pad;

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .d_i   (gpio_i),
    .q_o   (sync_q)
  );

  gpio_rstcap #(.W(CAP_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sync_q[CAP_W-1:0]),
    .cap_o  (cap_q),
    .vld_o  (cap_vld_q)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    localparam int W    = bank_width(NUM_PINS, k);
    localparam int BASE = k * BANK_W;
    logic set_we, clr_we, inp_we;

    assign set_we = we_i && (addr_i == ADDR_W'(k * REG_STRIDE + OFF_SET));
    assign clr_we = we_i && (addr_i == ADDR_W'(k * REG_STRIDE + OFF_CLR));
    assign inp_we = we_i && (addr_i == ADDR_W'(k * REG_STRIDE + OFF_INP));

    gpio_bank #(.W(W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_we_i (set_we),
      .clr_we_i (clr_we),
      .inp_we_i (inp_we),
      .wdata_i  (wdata_i[W-1:0]),
      .lvl_i    (sync_q[BASE +: W]),
      .out_o    (gpio_o[BASE +: W]),
      .oe_o     (gpio_oe_o[BASE +: W]),
      .irq_o    (irq_o[BASE +: W])
    );
  end

  assign lvl_pad = PAD_W'(sync_q);
  assign cap_pad = CAP_PAD_W'(cap_q);

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (addr_i == ADDR_W'(k * REG_STRIDE + OFF_SET))
        rdata_o = lvl_pad[k*BANK_W +: BANK_W];
    end
    for (int w = 0; w < CAP_WORDS; w++) begin
      if (addr_i == ADDR_W'(CAP_BASE + 4 * w))
        rdata_o = cap_pad[w*BANK_W +: BANK_W];
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_PINS = 75,
  parameter int CAP_W    = 64,
  parameter int ADDR_W   = 10
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         wdata_i,
  input logic                we_i,
  input logic [NUM_PINS-1:0] gpio_o,
  input logic [NUM_PINS-1:0] gpio_oe_o,
  input logic [NUM_PINS-1:0] irq_o,
  input logic [CAP_W-1:0]    cap_q,
  input logic                cap_vld_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (gpio_oe_o == '0 && gpio_o == '0 && irq_o == '0); // R1
    end
  end

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(0)) |=>
      ((gpio_oe_o[31:0] & gpio_o[31:0] & $past(wdata_i)) == $past(wdata_i))); // R2

  AST_CLR_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(4)) |=>
      ((gpio_oe_o[31:0] & ~gpio_o[31:0] & $past(wdata_i)) == $past(wdata_i))); // R3

  AST_INP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(8)) |=> ((gpio_oe_o[31:0] & $past(wdata_i)) == '0)); // R4

  AST_DIR_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(gpio_oe_o)); // R4

  AST_CAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_vld_q && $past(cap_vld_q)) |-> $stable(cap_q)); // R6

  AST_IRQ_ONLY_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & gpio_oe_o) == '0); // R8
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .CAP_W    (CAP_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .we_i      (we_i),
  .gpio_o    (gpio_o),
  .gpio_oe_o (gpio_oe_o),
  .irq_o     (irq_o),
  .cap_q     (cap_q),
  .cap_vld_q (cap_vld_q)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 75;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b1;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic          we = 1'b0;
  logic [31:0]   rdata;
  logic [NP-1:0] gpio_i, gpio_o, gpio_oe, irq;
  logic [NP-1:0] ext_lvl = '0;
  logic [NP-1:0] m_o = '0, m_oe = '0;
  logic [NP-1:0] cap_pat;
  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign gpio_i = (gpio_oe & gpio_o) | (~gpio_oe & ext_lvl);

  gpio_bank_ctrl u_gpio_bank_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .we_i      (we),
    .rdata_o   (rdata),
    .gpio_i    (gpio_i),
    .gpio_o    (gpio_o),
    .gpio_oe_o (gpio_oe),
    .irq_o     (irq)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (a < 10'h60 && (a[4:0] == 5'h0 || a[4:0] == 5'h4 || a[4:0] == 5'h8)) begin
      for (int b = 0; b < 32; b++) begin
        int p;
        p = int'(a[9:5]) * 32 + b;
        if (p < NP && d[b]) begin
          case (a[4:0])
            5'h0: begin m_o[p] = 1'b1; m_oe[p] = 1'b1; end
            5'h4: begin m_o[p] = 1'b0; m_oe[p] = 1'b1; end
            default: m_oe[p] = 1'b0;
          endcase
        end
      end
    end
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] exp_word(input int k);
    logic [127:0] lv;
    lv = 128'((m_oe & m_o) | (~m_oe & ext_lvl));
    return lv[k*32 +: 32];
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_capture();
    logic [31:0] d;
    ext_lvl = 75'h4_1234_5678_9ABC_DEF0;
    cap_pat = ext_lvl;
    #1 rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 oe in reset", 128'(gpio_oe), '0);
    check("R1 out in reset", 128'(gpio_o), '0);
    check("R1 irq in reset", 128'(irq), '0);
    rst_ni = 1'b1;
    @(negedge clk);
    ext_lvl = 75'h2_0F0F_0F0F_F0F0_F0F0;
    settle();
    bus_rd(10'h200, d); check("R6 capture word 0", 128'(d), 128'(cap_pat[31:0]));
    bus_rd(10'h204, d); check("R6 capture word 1", 128'(d), 128'(cap_pat[63:32]));
    bus_wr(10'h200, 32'h0);
    bus_rd(10'h200, d); check("R6 capture ignores write", 128'(d), 128'(cap_pat[31:0]));
    bus_rd(10'h000, d); check("R5 bank0 readback after reset", 128'(d), 128'(exp_word(0)));
    check("R8 irq follows inputs", 128'(irq), 128'(~m_oe & ext_lvl));
  endtask

  task automatic t_set_bank1();
    logic [31:0] d;
    bus_wr(10'h020, 32'h0000_00F0);  // R9 bank 1 at 0x20
    check("R2 oe after set", 128'(gpio_oe), 128'(m_oe));
    check("R2 out after set", 128'(gpio_o), 128'(m_o));
    settle();
    bus_rd(10'h020, d); check("R5 bank1 readback driven", 128'(d), 128'(exp_word(1)));
  endtask

  task automatic t_clear_bank0();
    logic [31:0] d;
    ext_lvl[1:0] = 2'b11;
    bus_wr(10'h004, 32'h0000_0003);
    check("R3 oe after clear", 128'(gpio_oe), 128'(m_oe));
    check("R3 out after clear", 128'(gpio_o), 128'(m_o));
    settle();
    bus_rd(10'h000, d); check("R5 bank0 readback low", 128'(d), 128'(exp_word(0)));
  endtask

  task automatic t_release_bank1();
    bus_wr(10'h028, 32'h0000_0030);
    check("R4 oe after release", 128'(gpio_oe), 128'(m_oe));
    check("R4 out latch kept", 128'(gpio_o), 128'(m_o));
    repeat (5) @(negedge clk);
    check("R4 oe stable idle", 128'(gpio_oe), 128'(m_oe));
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    bus_wr(10'h040, 32'hFFFF_FFFF);  // R9 bank 2 at 0x40
    check("R7 oe upper pins", 128'(gpio_oe), 128'(m_oe));
    settle();
    bus_rd(10'h040, d); check("R7 bank2 unimplemented bits zero", 128'(d), 128'(32'h0000_07FF));
    bus_rd(10'h060, d); check("R7 unmapped bank3", 128'(d), '0);
    bus_rd(10'h00C, d); check("R7 unmapped offset", 128'(d), '0);
    bus_rd(10'h208, d); check("R7 unmapped capture word", 128'(d), '0);
  endtask

  task automatic t_irq_collide();
    ext_lvl[5] = 1'b1;
    bus_wr(10'h008, 32'h0000_0020);
    settle();
    check("R8 irq high on input pin", 128'(irq[5]), 128'(1));
    bus_wr(10'h000, 32'h0000_0020);
    check("R8 irq drops at set edge", 128'(irq[5]), 128'(0));
    check("R2 oe rises at set edge", 128'(gpio_oe[5]), 128'(1));
    bus_wr(10'h008, 32'h0000_0020);
    check("R8 irq rises at release edge", 128'(irq[5]), 128'(1));
    settle();
    check("R8 irq vector", 128'(irq), 128'(~m_oe & ext_lvl));
  endtask

  initial begin
    t_reset_capture();
    t_set_bank1();
    t_clear_bank0();
    t_release_bank1();
    t_unimpl();
    t_irq_collide();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule